// File: doc/BRIEF.md
# Multi-format serial audio input receiver

This block deserializes an incoming serial audio stream into parallel sample words. It watches three external lines: a bit clock, a frame clock (or a frame-sync pulse in multi-slot mode) and a data line. It resamples all three into the core clock domain. It recognises the start of each channel or slot and collects the bits of each word, most significant bit first. At the end of each word it presents the sample, its channel or slot number and a one-cycle strobe.

There are four framings, chosen by `fmt_i`. The word length is chosen by `wlen_i` and applies in every framing. Both selects are meant to be set while the block is in reset and to stay fixed while audio is flowing. Each sample is placed in a fixed-point word: its most significant bit sits at the fraction's sign position, the guard bits above it copy that sign, and the unused low bits are zero.

Top module: `audio_serial_rx`

## Requirements
- R1: With `fmt_i`=0 (two-channel, delayed), a frame-clock level of low marks channel 0 and high marks channel 1. Each word's MSB arrives on the second bit-clock rise after the frame-clock transition.
- R2: With `fmt_i`=1 (two-channel, left-aligned), frame-clock high marks channel 0 and low marks channel 1. The MSB arrives on the first bit-clock rise after the transition.
- R3: With `fmt_i`=2 (two-channel, right-aligned), the channel levels are as in R2. Each channel lasts 32 bit clocks, and the LSB arrives on the 32nd bit-clock rise after the transition.
- R4: With `fmt_i`=3 (multi-slot), the first bit-clock rise that samples the sync line high carries the MSB of slot 0. Slot n starts 32·n bit clocks later. `chan_o` gives the slot number, 0 to 7. Bits after slot 7 produce no sample.
- R5: `wlen_i` selects the word length: 0 gives 16 bits, 1 gives 20 bits, and 2 or 3 give 24 bits. Bits outside the word window of the channel or slot have no effect on any output.
- R6: `sample_o` holds the word's MSB at bit 23. Bits 27:24 are copies of the MSB, the word's following bits lie below bit 23, and bits below the LSB are zero.
- R7: `valid_o` is high for exactly one clock per received word. `sample_o` and `chan_o` change only in a cycle where `valid_o` is high and hold their values in every other cycle.
- R8: The frame-clock and data lines are sampled at the rising edge of the bit clock. The bit clock must stay high for at least three core clocks and low for at least three core clocks.
- R9: During and after reset, `sample_o`, `chan_o` and `valid_o` are zero. No sample is produced from bits received before the first frame-clock transition (or sync rise) seen after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | External bit clock |
| fclk_i | input | 1 | External frame clock or frame-sync pulse |
| sdata_i | input | 1 | External serial data |
| fmt_i | input | 2 | Framing select: 0 delayed, 1 left-aligned, 2 right-aligned, 3 multi-slot |
| wlen_i | input | 2 | Word length select: 0 = 16, 1 = 20, 2 or 3 = 24 bits |
| sample_o | output | 28 | Received sample, sign-extended and left-aligned at bit 23 |
| chan_o | output | 3 | Channel (0/1) or slot (0..7) number of `sample_o` |
| valid_o | output | 1 | One-clock strobe marking a new sample |

## Verification
The bound checker watches every cycle for three things: that the strobe is a single-cycle pulse, that the outputs hold between strobes, and that every presented word is correctly sign-extended. It also checks that 16-bit words carry zero low bits and that the two-channel framings report only channel 0 or 1. Several behaviours are left to the bench's directed frames, because only a frame can expose them: where each word sits relative to the frame edge in each framing, which frame-clock level maps to which channel, that bits outside the window are ignored, and that a partial frame after reset is discarded. The bench checks each of these by driving known words surrounded by ones and comparing what arrives.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    FMT_DLY   = 2'd0,
    FMT_LEFT  = 2'd1,
    FMT_RIGHT = 2'd2,
    FMT_SLOT  = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    WL_16  = 2'd0,
    WL_20  = 2'd1,
    WL_24  = 2'd2,
    WL_24B = 2'd3
  } wlen_e;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int STAGES = 2,
  parameter int N      = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [STAGES-1:0][N-1:0] st_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= {st_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/sar_framer.sv
module sar_framer
  import sar_pkg::*;
#(
  parameter int SLOT_BITS = 32,
  parameter int MAX_SLOTS = 8,
  parameter int MAX_W     = 24,
  localparam int CH_W     = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
  localparam int WB_W     = $clog2(MAX_W + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bclk_s_i,
  input  logic            fs_s_i,
  input  fmt_e            fmt_i,
  input  logic [WB_W-1:0] wbits_i,
  output logic            bit_en_o,
  output logic            win_o,
  output logic            last_o,
  output logic [CH_W-1:0] chan_o
);
  localparam int SLOT_LG = $clog2(SLOT_BITS);
  localparam int CNT_W   = $clog2(SLOT_BITS * MAX_SLOTS) + 1;
  localparam int SLOT_W  = CNT_W - SLOT_LG;
  localparam logic [CNT_W-1:0]   CNT_MAX = {CNT_W{1'b1}};
  localparam logic [SLOT_LG:0]   SLOT_X  = (SLOT_LG+1)'(SLOT_BITS);
  localparam logic [SLOT_LG:0]   ONE_X   = (SLOT_LG+1)'(1);
  localparam logic [SLOT_W-1:0]  NSLOT_X = SLOT_W'(MAX_SLOTS);

  logic             bclk_d_q, fs_d_q, seen_q, locked_q;
  logic [CNT_W-1:0] cnt_q, pos_c;
  logic [CH_W-1:0]  ch_q;

  logic             tdm, frame_edge, stereo_ch, slot_ok, locked_now;
  logic [SLOT_W-1:0] slot_c;
  logic [SLOT_LG:0] off_x, wb_x, start_c, end_c;

  assign bit_en_o = bclk_s_i & ~bclk_d_q;
  assign tdm      = (fmt_i == FMT_SLOT);

  always_comb begin
    frame_edge = seen_q & (tdm ? (fs_s_i & ~fs_d_q) : (fs_s_i ^ fs_d_q));
    if (frame_edge)           pos_c = '0;
    else if (cnt_q == CNT_MAX) pos_c = cnt_q;
    else                      pos_c = cnt_q + CNT_W'(1);
    // delayed framing: low level is channel 0; aligned framings: high level
    stereo_ch  = (fmt_i == FMT_DLY) ? fs_s_i : ~fs_s_i;
    slot_c     = pos_c[CNT_W-1:SLOT_LG];
    off_x      = {1'b0, pos_c[SLOT_LG-1:0]};
    slot_ok    = tdm ? (slot_c < NSLOT_X) : (slot_c == '0);
    locked_now = locked_q | frame_edge;
    wb_x       = (SLOT_LG+1)'(wbits_i);
    unique case (fmt_i)
      FMT_DLY:   start_c = ONE_X;
      FMT_RIGHT: start_c = SLOT_X - wb_x;
      default:   start_c = '0;
    endcase
    end_c  = start_c + wb_x - ONE_X;
    win_o  = locked_now & slot_ok & (off_x >= start_c) & (off_x <= end_c);
    last_o = win_o & (off_x == end_c);
    if (tdm)             chan_o = slot_c[CH_W-1:0];
    else if (frame_edge) chan_o = CH_W'(stereo_ch);
    else                 chan_o = ch_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_d_q <= 1'b0;
      fs_d_q   <= 1'b0;
      seen_q   <= 1'b0;
      locked_q <= 1'b0;
      cnt_q    <= '0;
      ch_q     <= '0;
    end else begin
      bclk_d_q <= bclk_s_i;
      if (bit_en_o) begin
        fs_d_q <= fs_s_i;
        seen_q <= 1'b1;
        cnt_q  <= pos_c;
        if (frame_edge) locked_q <= 1'b1;
        if (frame_edge && !tdm) ch_q <= CH_W'(stereo_ch);
      end
    end
  end
endmodule

// File: rtl/sar_shifter.sv
module sar_shifter #(
  parameter int MAX_W = 24,
  parameter int OUT_W = 28,
  parameter int CH_W  = 3,
  localparam int WB_W = $clog2(MAX_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_en_i,
  input  logic             win_i,
  input  logic             last_i,
  input  logic             sd_i,
  input  logic [WB_W-1:0]  wbits_i,
  input  logic [CH_W-1:0]  chan_i,
  output logic [OUT_W-1:0] sample_o,
  output logic [CH_W-1:0]  chan_o,
  output logic             valid_o
);
  localparam logic [WB_W-1:0] MAX_WB = WB_W'(MAX_W);

  logic [MAX_W-1:0] sh_q, full_c, algn_c;
  logic [WB_W-1:0]  shamt_c;
  logic [OUT_W-1:0] ext_c;

  always_comb begin
    full_c  = {sh_q[MAX_W-2:0], sd_i};
    shamt_c = MAX_WB - wbits_i;
    algn_c  = full_c << shamt_c;
    ext_c   = {{(OUT_W-MAX_W){algn_c[MAX_W-1]}}, algn_c};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      sample_o <= '0;
      chan_o   <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (bit_en_i && win_i) sh_q <= full_c;
      if (bit_en_i && last_i) begin
        valid_o  <= 1'b1;
        sample_o <= ext_c;
        chan_o   <= chan_i;
      end
    end
  end
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import sar_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SLOT_BITS   = 32,
  parameter int MAX_SLOTS   = 8,
  parameter int MAX_W       = 24,
  parameter int OUT_W       = 28,
  localparam int CH_W       = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
  localparam int WB_W       = $clog2(MAX_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bclk_i,
  input  logic             fclk_i,
  input  logic             sdata_i,
  input  logic [1:0]       fmt_i,
  input  logic [1:0]       wlen_i,
  output logic [OUT_W-1:0] sample_o,
  output logic [CH_W-1:0]  chan_o,
  output logic             valid_o
);
  logic [2:0]      line_s;
  logic [WB_W-1:0] wbits;
  logic            bit_en, win, last;
  logic [CH_W-1:0] chan_c;

  always_comb begin
    unique case (wlen_e'(wlen_i))
      WL_16:   wbits = WB_W'(16);
      WL_20:   wbits = WB_W'(20);
      default: wbits = WB_W'(MAX_W);
    endcase
  end

  sar_sync #(.STAGES(SYNC_STAGES), .N(3)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({bclk_i, fclk_i, sdata_i}),
    .q_o    (line_s)
  );

  sar_framer #(.SLOT_BITS(SLOT_BITS), .MAX_SLOTS(MAX_SLOTS), .MAX_W(MAX_W)) u_framer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bclk_s_i (line_s[2]),
    .fs_s_i   (line_s[1]),
    .fmt_i    (fmt_e'(fmt_i)),
    .wbits_i  (wbits),
    .bit_en_o (bit_en),
    .win_o    (win),
    .last_o   (last),
    .chan_o   (chan_c)
  );

  sar_shifter #(.MAX_W(MAX_W), .OUT_W(OUT_W), .CH_W(CH_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_i (bit_en),
    .win_i    (win),
    .last_i   (last),
    .sd_i     (line_s[0]),
    .wbits_i  (wbits),
    .chan_i   (chan_c),
    .sample_o (sample_o),
    .chan_o   (chan_o),
    .valid_o  (valid_o)
  );
endmodule

// File: rtl/audio_serial_rx_chk.sv
module audio_serial_rx_chk #(
  parameter int MAX_SLOTS = 8,
  parameter int MAX_W     = 24,
  parameter int OUT_W     = 28,
  localparam int CH_W     = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       fmt_i,
  input logic [1:0]       wlen_i,
  input logic [OUT_W-1:0] sample_o,
  input logic [CH_W-1:0]  chan_o,
  input logic             valid_o
);
  localparam int EXT_N = OUT_W - MAX_W + 1;

  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R7

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(sample_o) && $stable(chan_o))); // R7

  AST_SIGN_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($countones(sample_o[OUT_W-1:MAX_W-1]) == 0 ||
                 $countones(sample_o[OUT_W-1:MAX_W-1]) == EXT_N)); // R6

  AST_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && wlen_i == 2'd0) |-> (sample_o[MAX_W-17:0] == '0)); // R5

  AST_STEREO_CH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && fmt_i != 2'd3) |-> (chan_o <= CH_W'(1))); // R2
endmodule

bind audio_serial_rx audio_serial_rx_chk #(
  .MAX_SLOTS (MAX_SLOTS),
  .MAX_W     (MAX_W),
  .OUT_W     (OUT_W)
) u_chk (.*);

// File: tb/tb_audio_serial_rx.sv
module tb_audio_serial_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bclk = 1'b0, fclk = 1'b0, sdata = 1'b0;
  logic [1:0] fmt = 2'd0, wlen = 2'd2;
  logic [27:0] sample;
  logic [2:0]  chan;
  logic        valid;

  int n_chk = 0, n_fail = 0;
  int n_got = 0, run_len = 0, max_run = 0;
  logic [27:0] got_s [0:31];
  logic [2:0]  got_c [0:31];
  logic [27:0] last_exp;

  always #10 clk = ~clk;

  audio_serial_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .fclk_i(fclk), .sdata_i(sdata),
    .fmt_i(fmt), .wlen_i(wlen), .sample_o(sample), .chan_o(chan), .valid_o(valid)
  );

  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (n_got < 32) begin
        got_s[n_got] = sample;
        got_c[n_got] = chan;
      end
      n_got = n_got + 1;
      run_len = run_len + 1;
      if (run_len > max_run) max_run = run_len;
    end else run_len = 0;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [27:0] exp_word(input logic [23:0] v, input int w);
    logic [23:0] a;
    a = v << (24 - w);
    return {{4{a[23]}}, a};
  endfunction

  function automatic logic bit_at(input int f, input int w, input int idx, input logic [23:0] v);
    int st;
    st = (f == 0) ? 1 : (f == 2) ? 32 - w : 0;
    if (idx >= st && idx < st + w) return v[w-1-(idx-st)];
    return 1'b1;
  endfunction

  task automatic send_bit(input logic f, input logic d);
    @(negedge clk);
    fclk = f; sdata = d;
    repeat (3) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
    bclk = 1'b0;
  endtask

  task automatic send_chan(input int f, input int w, input logic lvl, input logic [23:0] v);
    for (int i = 0; i < 32; i++) send_bit(lvl, bit_at(f, w, i, v));
  endtask

  task automatic do_reset(input logic [1:0] f, input logic [1:0] wl);
    rst_n = 1'b0; bclk = 1'b0; fclk = 1'b0; sdata = 1'b0;
    fmt = f; wlen = wl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n_got = 0; max_run = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset(2'd0, 2'd2);
    chk(sample == '0, "R9 reset sample", 32'(sample), 0);
    chk(chan == '0, "R9 reset chan", 32'(chan), 0);
    chk(valid == 1'b0, "R9 reset valid", 32'(valid), 0);
  endtask

  task automatic t_stereo(input int f, input int w, input logic [1:0] wl,
                          input logic lv0, input logic [23:0] l, input logic [23:0] r,
                          input string req);
    do_reset(2'(f), wl);
    send_chan(f, w, ~lv0, 24'hA5A5A5);  // partial channel before first edge
    send_chan(f, w, lv0, l);
    send_chan(f, w, ~lv0, r);
    repeat (10) @(negedge clk);
    chk(n_got == 2, {req, " R9 sample count"}, n_got, 2);
    chk(got_s[0] == exp_word(l, w), {req, " R6 ch0 word"}, 32'(got_s[0]), 32'(exp_word(l, w)));
    chk(got_c[0] == 3'd0, {req, " ch0 index"}, 32'(got_c[0]), 0);
    chk(got_s[1] == exp_word(r, w), {req, " R5 R8 ch1 word"}, 32'(got_s[1]), 32'(exp_word(r, w)));
    chk(got_c[1] == 3'd1, {req, " ch1 index"}, 32'(got_c[1]), 1);
    last_exp = exp_word(r, w);
  endtask

  task automatic t_tdm();
    logic [23:0] v;
    do_reset(2'd3, 2'd2);
    for (int i = 0; i < 8; i++) send_bit(1'b0, 1'b1);
    for (int i = 0; i < 272; i++) begin
      int s, o;
      s = i / 32; o = i % 32;
      v = 24'(s * 32'h1F3A71) ^ 24'h80A5C3;
      send_bit(i == 0, (s < 8 && o < 24) ? v[23-o] : 1'b1);
    end
    repeat (10) @(negedge clk);
    chk(n_got == 8, "R4 slot count", n_got, 8);
    for (int s = 0; s < 8; s++) begin
      v = 24'(s * 32'h1F3A71) ^ 24'h80A5C3;
      chk(got_s[s] == exp_word(v, 24), "R4 slot word", 32'(got_s[s]), 32'(exp_word(v, 24)));
      chk(got_c[s] == 3'(s), "R4 slot index", 32'(got_c[s]), s);
    end
    last_exp = exp_word(24'(7 * 32'h1F3A71) ^ 24'h80A5C3, 24);
  endtask

  task automatic t_pulse();
    chk(max_run == 1, "R7 strobe width", max_run, 1);
    chk(sample == last_exp && valid == 1'b0, "R7 hold", 32'(sample), 32'(last_exp));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_stereo(0, 24, 2'd2, 1'b0, 24'h123456, 24'h876543, "R1");
    t_stereo(1, 16, 2'd0, 1'b1, 24'h008001, 24'h007FFE, "R2");
    t_stereo(2, 20, 2'd1, 1'b1, 24'h0ABCDE, 24'h001234, "R3");
    t_stereo(2, 24, 2'd3, 1'b1, 24'hF00F0F, 24'h7F0001, "R3 R5");
    t_pulse();
    t_tdm();
    t_pulse();
    finish_run();
  end
endmodule